// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers interrupt request lines from many peripherals into a small number of groups and presents them to a processor. Every group holds up to 32 sticky pending bits. A pending bit is captured on a rising edge of its line and stays pending until software acknowledges it by writing a one to it. Each group also holds an enable mask. Software changes that mask through a pair of write-one registers, one that turns bits on and one that turns bits off, so a bit can be changed without a read-modify-write. A read-only result word shows which pending bits are also enabled.

At the top level, each group contributes a single bit, which a block enable mask gates. The block enable mask has its own set and clear registers. Group `n` sits at bit `(n + 8) mod 32` of every block-level word. The gated bits drive one interrupt output per group and appear in a read-only vector word. A separate control bit selects an alternate routing mode, in which sources go directly to the processor. The block only drives that bit out and does nothing else with it.

Software reaches all registers through a simple single-cycle 32-bit port with word addressing. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all of the following are zero: the pending bits, the group enables, the block enables and the control bit. Every register reads 0, `grp_irq_o` is 0 and `direct_mode_o` is 0.
- R2: A pending bit becomes 1 in the cycle after its line rises from 0 to 1. It stays 1 while the line stays high and after the line falls. A line that is held high sets its bit only once.
- R3: Group `g` owns the word at address `5g+0`, which reads its pending bits. Writing a 1 to a bit of that word clears it, and writing a 0 leaves it unchanged. If a rising edge arrives in the same cycle as the clearing write, the bit stays set.
- R4: Writing a 1 to a bit of the word at `5g+1` enables that source, and writing a 0 leaves it unchanged. Reading `5g+1` returns the group's enable mask.
- R5: Writing a 1 to a bit of the word at `5g+2` disables that source, and writing a 0 leaves it unchanged. Writing all ones disables the whole group. Reading `5g+2` also returns the enable mask.
- R6: The word at `5g+3` reads pending AND enable. Writes to it change nothing.
- R7: Let `B = 5*NUM_GROUPS`. The word at `B+0` is the block enable-set register and the word at `B+1` is the block enable-clear register. Group `g` uses bit `(g+8) mod 32` in both, and a 1 sets or clears that bit respectively. Both words read the block enable mask at those bit positions.
- R8: The word at `B+2` is a read-only vector. Bit `(g+8) mod 32` of that word, and `grp_irq_o[g]`, is 1 exactly when the group has any result bit set and its block enable bit is set.
- R9: Bit 0 of the word at `B+3` is a read/write control bit that drives `direct_mode_o`. All other bits of that word read 0.
- R10: Three kinds of location read 0 and ignore writes: the reserved word at `5g+4`, any address at or above `B+4`, and any block-level bit that belongs to no implemented group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lines_i | input | NUM_GROUPS*SRC_W | Interrupt lines; group g uses bits [g*SRC_W +: SRC_W] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| grp_irq_o | output | NUM_GROUPS | Gated interrupt output, one per group |
| direct_mode_o | output | 1 | Alternate direct-routing mode select |

## Verification
The pending bits, the enable masks and the block mask are all held state. If any of them is wrong, the error shows in the readback of its own word in the cycle after the write or edge that should have changed it. It also shows on `grp_irq_o` and in the vector word in that same cycle, because the gating path after the registers has no extra stage. The bench therefore reads the affected word and the outputs one cycle after each stimulus. It also checks the cases where a state change would be silent: a clear that races an edge, writes to read-only and reserved words, and a line held high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORDS_PER_GRP = 5;
  localparam int unsigned BLK_BIT_OFS   = 8;
  localparam int unsigned REG_W         = 32;

  typedef enum int unsigned {
    SLOT_PEND   = 0,
    SLOT_EN_SET = 1,
    SLOT_EN_CLR = 2,
    SLOT_RESULT = 3,
    SLOT_RSVD   = 4
  } grp_slot_e;

  typedef enum int unsigned {
    BLK_EN_SET = 0,
    BLK_EN_CLR = 1,
    BLK_VECTOR = 2,
    BLK_CTRL   = 3
  } blk_slot_e;

  function automatic int unsigned blk_bit(input int unsigned grp);
    return (grp + BLK_BIT_OFS) % REG_W;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] line_i,
  input  logic             pend_clr_we,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] pend_o,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] result_o,
  output logic             any_o
);
  logic [SRC_W-1:0] line_q, pend_q, en_q;
  logic [SRC_W-1:0] rise, clr_mask, set_mask, off_mask;
  logic [SRC_W-1:0] pend_d, en_d;
  logic             pend_ld, en_ld;

  always_comb begin
    rise     = line_i & ~line_q;
    clr_mask = pend_clr_we ? wdata_i : '0;
    set_mask = en_set_we   ? wdata_i : '0;
    off_mask = en_clr_we   ? wdata_i : '0;
    pend_d   = (pend_q & ~clr_mask) | rise;
    en_d     = (en_q | set_mask) & ~off_mask;
    pend_ld  = pend_clr_we | (|rise);
    en_ld    = en_set_we | en_clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      line_q <= line_i;
      if (pend_ld) pend_q <= pend_d;
      if (en_ld)   en_q   <= en_d;
    end
  end

  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign result_o = pend_q & en_q;
  assign any_o    = |result_o;

  // R2
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(line_i & ~line_q)) == $past(line_i & ~line_q)));
  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_set_we || en_clr_we) |=> $stable(en_q));
  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((en_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned SRC_W      = 32,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*SRC_W-1:0] irq_lines_i,
  input  logic                        reg_wr_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  output logic [NUM_GROUPS-1:0]       grp_irq_o,
  output logic                        direct_mode_o
);
  localparam int unsigned BLK_BASE = WORDS_PER_GRP * NUM_GROUPS;

  logic                  rst_s;
  logic [SRC_W-1:0]      pend_a [NUM_GROUPS];
  logic [SRC_W-1:0]      en_a   [NUM_GROUPS];
  logic [SRC_W-1:0]      res_a  [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] any_v;
  logic [NUM_GROUPS-1:0] blk_en_q, blk_en_d;
  logic                  blk_ld, ctrl_q, ctrl_ld;
  logic                  wr_blk_set, wr_blk_clr;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned GBASE = g * WORDS_PER_GRP;
    logic hit_pend, hit_set, hit_clr;

    assign hit_pend = reg_wr_i && (reg_addr_i == ADDR_W'(GBASE + SLOT_PEND));
    assign hit_set  = reg_wr_i && (reg_addr_i == ADDR_W'(GBASE + SLOT_EN_SET));
    assign hit_clr  = reg_wr_i && (reg_addr_i == ADDR_W'(GBASE + SLOT_EN_CLR));

    irq_group #(.SRC_W(SRC_W)) u_grp (
      .clk         (clk),
      .rst_n       (rst_s),
      .line_i      (irq_lines_i[g*SRC_W +: SRC_W]),
      .pend_clr_we (hit_pend),
      .en_set_we   (hit_set),
      .en_clr_we   (hit_clr),
      .wdata_i     (reg_wdata_i[SRC_W-1:0]),
      .pend_o      (pend_a[g]),
      .en_o        (en_a[g]),
      .result_o    (res_a[g]),
      .any_o       (any_v[g])
    );

    // R8
    blk_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (wr_blk_clr && reg_wdata_i[blk_bit(g)]) |=> !grp_irq_o[g]);
  end

  assign wr_blk_set = reg_wr_i && (reg_addr_i == ADDR_W'(BLK_BASE + BLK_EN_SET));
  assign wr_blk_clr = reg_wr_i && (reg_addr_i == ADDR_W'(BLK_BASE + BLK_EN_CLR));
  assign ctrl_ld    = reg_wr_i && (reg_addr_i == ADDR_W'(BLK_BASE + BLK_CTRL));
  assign blk_ld     = wr_blk_set | wr_blk_clr;

  always_comb begin
    blk_en_d = blk_en_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (wr_blk_set && reg_wdata_i[blk_bit(g)]) blk_en_d[g] = 1'b1;
      if (wr_blk_clr && reg_wdata_i[blk_bit(g)]) blk_en_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      blk_en_q <= '0;
      ctrl_q   <= 1'b0;
    end else begin
      if (blk_ld)  blk_en_q <= blk_en_d;
      if (ctrl_ld) ctrl_q   <= reg_wdata_i[0];
    end
  end

  assign grp_irq_o     = any_v & blk_en_q;
  assign direct_mode_o = ctrl_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr_i == ADDR_W'(g * WORDS_PER_GRP + SLOT_PEND))
        reg_rdata_o[SRC_W-1:0] = pend_a[g];
      if (reg_addr_i == ADDR_W'(g * WORDS_PER_GRP + SLOT_EN_SET) ||
          reg_addr_i == ADDR_W'(g * WORDS_PER_GRP + SLOT_EN_CLR))
        reg_rdata_o[SRC_W-1:0] = en_a[g];
      if (reg_addr_i == ADDR_W'(g * WORDS_PER_GRP + SLOT_RESULT))
        reg_rdata_o[SRC_W-1:0] = res_a[g];
      if (reg_addr_i == ADDR_W'(BLK_BASE + BLK_EN_SET) ||
          reg_addr_i == ADDR_W'(BLK_BASE + BLK_EN_CLR))
        reg_rdata_o[blk_bit(g)] = blk_en_q[g];
      if (reg_addr_i == ADDR_W'(BLK_BASE + BLK_VECTOR))
        reg_rdata_o[blk_bit(g)] = grp_irq_o[g];
    end
    if (reg_addr_i == ADDR_W'(BLK_BASE + BLK_CTRL))
      reg_rdata_o[0] = ctrl_q;
  end

  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !blk_ld |=> $stable(blk_en_q));
  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !ctrl_ld |=> $stable(direct_mode_o));
  // R9
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ctrl_ld |=> (direct_mode_o == $past(reg_wdata_i[0])));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int NG = 4;
  localparam int SW = 32;
  localparam int AW = 8;
  localparam int BB = 5 * NG;

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [NG-1:0] irq;
    logic          dm;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [NG*SW-1:0] lines;
  logic reg_wr;
  logic [AW-1:0] wr_addr, rd_addr, bus_addr;
  logic [31:0] wdata, rdata;
  logic [NG-1:0] grp_irq;
  logic dm;

  item_t q[$];
  int pushed = 0, done = 0, checks = 0, errors = 0;
  bit finished = 0;

  logic [SW-1:0] m_pend [NG];
  logic [SW-1:0] m_en   [NG];
  logic [NG-1:0] m_blk;
  logic          m_ctrl;

  always #10 clk = ~clk;

  assign bus_addr = reg_wr ? wr_addr : rd_addr;

  irq_aggregator #(.NUM_GROUPS(NG), .SRC_W(SW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .reg_wr_i(reg_wr),
    .reg_addr_i(bus_addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .grp_irq_o(grp_irq), .direct_mode_o(dm)
  );

  function automatic logic [NG-1:0] exp_irq();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = (|(m_pend[g] & m_en[g])) & m_blk[g];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    logic [31:0] r = '0;
    if (a < BB) begin
      case (a % 5)
        0: r = m_pend[a/5];
        1, 2: r = m_en[a/5];
        3: r = m_pend[a/5] & m_en[a/5];
        default: r = '0;
      endcase
    end else if (a == BB || a == BB + 1) r[8 +: NG] = m_blk;
    else if (a == BB + 2) r[8 +: NG] = exp_irq();
    else if (a == BB + 3) r[0] = m_ctrl;
    return r;
  endfunction

  task automatic model_wr(input int a, input logic [31:0] d);
    if (a < BB) begin
      case (a % 5)
        0: m_pend[a/5] = m_pend[a/5] & ~d;
        1: m_en[a/5]   = m_en[a/5] | d;
        2: m_en[a/5]   = m_en[a/5] & ~d;
        default: ;
      endcase
    end else if (a == BB)     m_blk = m_blk | d[8 +: NG];
    else if (a == BB + 1)     m_blk = m_blk & ~d[8 +: NG];
    else if (a == BB + 3)     m_ctrl = d[0];
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; wr_addr = AW'(a); wdata = d;
    model_wr(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_line(input int g, input int b, input logic v);
    @(negedge clk);
    if (v && !lines[g*SW+b]) m_pend[g][b] = 1'b1;
    lines[g*SW+b] = v;
  endtask

  // clearing write and rising edge in the same cycle
  task automatic race(input int g, input int b);
    @(negedge clk);
    reg_wr = 1'b1; wr_addr = AW'(g*5); wdata = 32'h1 << b;
    model_wr(g*5, 32'h1 << b);
    lines[g*SW+b] = 1'b1;
    m_pend[g][b] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input int a, input string tag);
    item_t it;
    it.addr = AW'(a); it.data = exp_rd(a); it.irq = exp_irq(); it.dm = m_ctrl;
    it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (done == pushed);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        rd_addr = it.addr;
        #2;
        checks++;
        if (rdata !== it.data || grp_irq !== it.irq || dm !== it.dm) begin
          errors++;
          $display("FAIL %s addr=%0d: got rdata=%h irq=%b dm=%b, expected rdata=%h irq=%b dm=%b",
                   it.tag, it.addr, rdata, grp_irq, dm, it.data, it.irq, it.dm);
        end
        done++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_pend[g] = '0; m_en[g] = '0; end
    m_blk = '0; m_ctrl = 1'b0;
    lines = '0; reg_wr = 1'b0; wr_addr = '0; rd_addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < BB + 4; a++) chk(a, "R1");

    // R2 edge capture, sticky after fall
    set_line(0, 3, 1'b1);
    set_line(0, 3, 1'b0);
    set_line(2, 31, 1'b1);
    set_line(2, 31, 1'b0);
    chk(0, "R2");
    chk(10, "R2");
    // R2/R3 held line sets once; clear while held stays clear
    set_line(1, 0, 1'b1);
    chk(5, "R2");
    wr(5, 32'h1);
    repeat (3) @(negedge clk);
    chk(5, "R3 held line");
    set_line(1, 0, 1'b0);

    // R4 enable set, R6 result
    wr(1, 32'h0000_000C);
    chk(1, "R4");
    chk(3, "R6");
    chk(BB + 2, "R8 blk off");
    // R7 block enable set with all ones, R10 unimplemented bits
    wr(BB, 32'hFFFF_FFFF);
    chk(BB, "R7");
    chk(BB + 1, "R7");
    chk(BB + 2, "R8");
    // R6 write to result ignored, R10 reserved and out-of-map
    wr(3, 32'h0);
    chk(3, "R6 write ignored");
    wr(4, 32'hFFFF_FFFF);
    wr(BB + 6, 32'hFFFF_FFFF);
    chk(4, "R10");
    chk(BB + 6, "R10");
    chk(0, "R10 no side effect");

    // R5 enable clear
    wr(2, 32'h0000_0004);
    chk(2, "R5");
    chk(3, "R5");
    wr(2, 32'hFFFF_FFFF);
    chk(1, "R5 all ones");
    chk(BB + 2, "R5 irq drop");

    // R3 clear with ones only
    wr(0, 32'h0000_0008);
    chk(0, "R3");
    wr(10, 32'h0);
    chk(10, "R3 zero write");
    // R3 edge wins over clear
    race(3, 5);
    chk(15, "R3 race");
    set_line(3, 5, 1'b0);

    // R8 block clear
    wr(11, 32'hFFFF_FFFF);
    chk(BB + 2, "R8");
    wr(BB + 1, 32'h0000_0400);
    chk(BB + 2, "R8 blk clr");
    chk(BB, "R7 blk clr");
    wr(BB + 1, 32'h0);
    chk(BB, "R7 zero write");

    // R9 control bit
    wr(BB + 3, 32'hFFFF_FFFF);
    chk(BB + 3, "R9");
    wr(BB + 3, 32'h0000_0000);
    chk(BB + 3, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule